// File: doc/BRIEF.md
# Load/Store Lane Alignment Unit

This unit sits between a 32-bit processor core and a little-endian, byte-addressed data bus. The core hands it one memory instruction word together with the base register value and the store source value. The unit adds the sign-extended 16-bit immediate to the base to form the byte address. It decodes the access width and, for loads, whether the result is sign- or zero-extended. It then drives the lane enables and places the store data on the lanes the address selects.

For loads, the unit takes the returned bus word and selects the addressed byte or halfword. It extends that value to 32 bits and returns it with the destination register index. Each access kind has two opcode forms that differ only in opcode bit 5, the cache-bypass form. The two forms behave the same, apart from a flag that the unit passes to the bus. Only one access is in flight at a time.

The request side follows valid/ready rules. An instruction transfers on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the unit is idle. On the bus side, `mem_valid` stays asserted until `mem_ready`, and all request fields stay frozen for the whole stall. Load data returns on `mem_rvalid`, which comes no earlier than the cycle after the request handshake. The result is a single-cycle pulse on `res_valid` and cannot be back-pressured.

Top module: `lsu_lane_unit`

## Requirements
- R1: `mem_addr` equals `req_base` plus the instruction's bits 21:6 sign-extended to 32 bits. `src_a_idx` presents instruction bits 31:27 combinationally so the core can read the base register.
- R2: `mem_be` is 4'b0001 shifted left by address bits 1:0 for byte accesses, 4'b0011 shifted left by 2*address bit 1 for halfword accesses, and 4'b1111 for word accesses.
- R3: Store data is replicated across the lanes: the low byte four times for byte stores, the low halfword twice for halfword stores, and the full word for word stores. `mem_write` is 1 for stores and 0 for loads.
- R4: Load results use opcode bits 4:0. Opcode 0x03 gives a zero-extended byte and 0x07 a sign-extended byte, taken from lane address[1:0]. Opcode 0x0B gives a zero-extended halfword and 0x0F a sign-extended halfword, taken from the half selected by address[1]. Opcode 0x17 gives the full word. Opcodes 0x05, 0x0D and 0x15 store a byte, a halfword and a word.
- R5: Setting opcode bit 5 (0x23, 0x27, 0x2B, 0x2F, 0x37, 0x25, 0x2D, 0x35) gives the same access as the bit-5-clear form. `mem_bypass` equals opcode bit 5.
- R6: While `mem_valid` is high and `mem_ready` is low, the next cycle keeps `mem_valid` high with `mem_addr`, `mem_be`, `mem_wdata` and `mem_write` unchanged.
- R7: A load raises `res_valid` for exactly one cycle, the cycle after `mem_rvalid`. `res_rd` then holds instruction bits 26:22 and `res_data` holds the extended value. Stores never raise `res_valid`.
- R8: `req_ready` is low from the cycle after an accepted memory instruction until its bus handshake (stores) or its response (loads) completes.
- R9: An accepted instruction whose opcode bits 4:0 are not one of the eight memory codes is dropped. It causes no bus request and no result.
- R10: After reset, `req_ready` is 1 and `mem_valid` and `res_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core offers an instruction |
| req_ready | output | 1 | Unit can take an instruction |
| req_instr | input | 32 | Instruction word |
| req_base | input | 32 | Value of the base register |
| req_store_data | input | 32 | Value of the store source register |
| src_a_idx | output | 5 | Base register index (bits 31:27) |
| mem_valid | output | 1 | Bus request valid |
| mem_ready | input | 1 | Bus accepts the request |
| mem_write | output | 1 | 1 for store, 0 for load |
| mem_addr | output | 32 | Byte address |
| mem_be | output | 4 | Lane enables |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_bypass | output | 1 | Cache-bypass form of the opcode |
| mem_rvalid | input | 1 | Load data returned |
| mem_rdata | input | 32 | Returned bus word |
| res_valid | output | 1 | Load result pulse |
| res_rd | output | 5 | Destination register index |
| res_data | output | 32 | Extended load value |

## Verification
The embedded properties check, on every cycle, the following:
- a stalled bus request holds all of its fields;
- no new instruction is taken while a request is outstanding;
- every result pulse follows a bus response;
- a store handshake produces no result;
- the lane-enable pattern always has one, two or four bits set;
- a dropped opcode raises no request.

Only the bench's scenarios can show the rest:
- the arithmetic correctness of the address;
- the exact lane placement of each enable pattern and each replicated store value;
- byte and halfword extraction and sign extension at every offset;
- the equivalence of the bypass opcode forms.

The bench covers these with random stalls, random response delays and directed negative-immediate and sign-bit cases.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned LANES   = WORD_W / 8;
  localparam int unsigned OFF_W   = $clog2(LANES);
  localparam int unsigned IMM_W   = 16;
  localparam int unsigned REG_W   = 5;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_WAIT = 2'd2
  } lsu_state_e;

  typedef struct packed {
    logic             legal;
    logic             is_store;
    logic             sext;
    logic             bypass;
    acc_size_e        size;
    logic [REG_W-1:0] rd;
  } acc_ctl_t;

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  output acc_ctl_t          ctl,
  output logic [IMM_W-1:0]  imm,
  output logic [REG_W-1:0]  a_idx
);

  logic [4:0] op_core;

  assign op_core = instr[4:0];
  assign imm     = instr[21:6];
  assign a_idx   = instr[31:27];

  always_comb begin
    ctl          = '0;
    ctl.rd       = instr[26:22];
    ctl.bypass   = instr[5];
    ctl.size     = SZ_BYTE;
    unique case (op_core)
      5'h03: begin ctl.legal = 1'b1; ctl.size = SZ_BYTE; end
      5'h07: begin ctl.legal = 1'b1; ctl.size = SZ_BYTE; ctl.sext = 1'b1; end
      5'h0B: begin ctl.legal = 1'b1; ctl.size = SZ_HALF; end
      5'h0F: begin ctl.legal = 1'b1; ctl.size = SZ_HALF; ctl.sext = 1'b1; end
      5'h17: begin ctl.legal = 1'b1; ctl.size = SZ_WORD; end
      5'h05: begin ctl.legal = 1'b1; ctl.is_store = 1'b1; ctl.size = SZ_BYTE; end
      5'h0D: begin ctl.legal = 1'b1; ctl.is_store = 1'b1; ctl.size = SZ_HALF; end
      5'h15: begin ctl.legal = 1'b1; ctl.is_store = 1'b1; ctl.size = SZ_WORD; end
      default: ctl.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/lsu_lane_fmt.sv
module lsu_lane_fmt
  import lsu_pkg::*;
(
  input  acc_size_e          size,
  input  logic [OFF_W-1:0]   offset,
  input  logic [WORD_W-1:0]  data_in,
  output logic [LANES-1:0]   be,
  output logic [WORD_W-1:0]  data_out
);

  logic [OFF_W-1:0] half_off;

  assign half_off = {offset[OFF_W-1:1], 1'b0};

  always_comb begin
    unique case (size)
      SZ_BYTE: be = LANES'(1) << offset;
      SZ_HALF: be = LANES'(3) << half_off;
      default: be = '1;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      unique case (size)
        SZ_BYTE: data_out[8*g +: 8] = data_in[7:0];
        SZ_HALF: data_out[8*g +: 8] = data_in[8*(g%2) +: 8];
        default: data_out[8*g +: 8] = data_in[8*g +: 8];
      endcase
    end
  end

endmodule

// File: rtl/lsu_load_ext.sv
module lsu_load_ext
  import lsu_pkg::*;
(
  input  acc_size_e          size,
  input  logic               sext,
  input  logic [OFF_W-1:0]   offset,
  input  logic [WORD_W-1:0]  bus_word,
  output logic [WORD_W-1:0]  value
);

  logic [WORD_W-1:0] byte_sh;
  logic [WORD_W-1:0] half_sh;
  logic [7:0]        b_val;
  logic [15:0]       h_val;

  assign byte_sh = bus_word >> {offset, 3'b000};
  assign half_sh = bus_word >> {offset[OFF_W-1:1], 4'b0000};
  assign b_val   = byte_sh[7:0];
  assign h_val   = half_sh[15:0];

  always_comb begin
    unique case (size)
      SZ_BYTE: value = {{(WORD_W-8){sext & b_val[7]}}, b_val};
      SZ_HALF: value = {{(WORD_W-16){sext & h_val[15]}}, h_val};
      default: value = bus_word;
    endcase
  end

endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_instr,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [31:0]       req_store_data,
  output logic [4:0]        src_a_idx,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  output logic              mem_bypass,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              res_valid,
  output logic [4:0]        res_rd,
  output logic [31:0]       res_data
);

  acc_ctl_t          dec_ctl;
  logic [IMM_W-1:0]  dec_imm;
  logic [ADDR_W-1:0] ea;
  logic [LANES-1:0]  fmt_be;
  logic [WORD_W-1:0] fmt_data;
  logic [WORD_W-1:0] ld_value;
  logic              accept;

  lsu_state_e        state_q;
  acc_ctl_t          ctl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  be_q;
  logic [WORD_W-1:0] wdata_q;

  lsu_decode u_dec (
    .instr (req_instr),
    .ctl   (dec_ctl),
    .imm   (dec_imm),
    .a_idx (src_a_idx)
  );

  assign ea = req_base + {{(ADDR_W-IMM_W){dec_imm[IMM_W-1]}}, dec_imm};

  lsu_lane_fmt u_fmt (
    .size     (dec_ctl.size),
    .offset   (ea[OFF_W-1:0]),
    .data_in  (req_store_data),
    .be       (fmt_be),
    .data_out (fmt_data)
  );

  lsu_load_ext u_ext (
    .size     (ctl_q.size),
    .sext     (ctl_q.sext),
    .offset   (addr_q[OFF_W-1:0]),
    .bus_word (mem_rdata),
    .value    (ld_value)
  );

  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign mem_valid  = (state_q == ST_BUS);
  assign mem_write  = ctl_q.is_store;
  assign mem_addr   = addr_q;
  assign mem_be     = be_q;
  assign mem_wdata  = wdata_q;
  assign mem_bypass = ctl_q.bypass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ctl_q   <= '0;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept && dec_ctl.legal) begin
            state_q <= ST_BUS;
            ctl_q   <= dec_ctl;
            addr_q  <= ea;
            be_q    <= fmt_be;
            wdata_q <= dec_ctl.is_store ? fmt_data : '0;
          end
        end
        ST_BUS: begin
          if (mem_ready) state_q <= ctl_q.is_store ? ST_IDLE : ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rvalid) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_rd    <= '0;
      res_data  <= '0;
    end else begin
      res_valid <= (state_q == ST_WAIT) && mem_rvalid;
      if ((state_q == ST_WAIT) && mem_rvalid) begin
        res_rd   <= ctl_q.rd;
        res_data <= ld_value;
      end
    end
  end

  // R6: a stalled request keeps every field
  a_r6_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_be)
                                   && $stable(mem_wdata) && $stable(mem_write)));

  // R8: no new instruction while the bus request is open
  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);

  // R7: every result pulse is preceded by a bus response
  a_r7_res_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(mem_rvalid));

  // R7: a store handshake yields no result
  a_r7_store_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_write) |=> !res_valid);

  // R2: lane enables cover one, two or four lanes
  a_r2_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
                   || $countones(mem_be) == 4));

  // R9: an unrecognised opcode never reaches the bus
  a_r9_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !dec_ctl.legal) |=> !mem_valid);

endmodule

// File: tb/lsu_lane_unit_tb.sv
module lsu_lane_unit_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_instr = '0;
  logic [31:0] req_base = '0;
  logic [31:0] req_store_data = '0;
  logic [4:0]  src_a_idx;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic        mem_write;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_bypass;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        res_valid;
  logic [4:0]  res_rd;
  logic [31:0] res_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_lane_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_instr(req_instr), .req_base(req_base), .req_store_data(req_store_data),
    .src_a_idx(src_a_idx), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_bypass(mem_bypass), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .res_valid(res_valid), .res_rd(res_rd), .res_data(res_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int op_size(input logic [5:0] op);
    case (op[4:0])
      5'h03, 5'h07, 5'h05: return 0;
      5'h0B, 5'h0F, 5'h0D: return 1;
      5'h17, 5'h15:        return 2;
      default:             return -1;
    endcase
  endfunction

  function automatic bit op_store(input logic [5:0] op);
    return (op[4:0] == 5'h05) || (op[4:0] == 5'h0D) || (op[4:0] == 5'h15);
  endfunction

  function automatic bit op_signed(input logic [5:0] op);
    return (op[4:0] == 5'h07) || (op[4:0] == 5'h0F);
  endfunction

  function automatic logic [3:0] exp_be(input int sz, input logic [1:0] off);
    if (sz == 0) return 4'b0001 << off;
    if (sz == 1) return off[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] exp_wdata(input int sz, input logic [31:0] d);
    if (sz == 0) return {4{d[7:0]}};
    if (sz == 1) return {2{d[15:0]}};
    return d;
  endfunction

  function automatic logic [31:0] exp_load(input int sz, input bit sg,
                                           input logic [1:0] off, input logic [31:0] w);
    logic [7:0]  b;
    logic [15:0] h;
    b = w[8*off +: 8];
    h = off[1] ? w[31:16] : w[15:0];
    if (sz == 0) return sg ? {{24{b[7]}}, b} : {24'h0, b};
    if (sz == 1) return sg ? {{16{h[15]}}, h} : {16'h0, h};
    return w;
  endfunction

  logic [31:0] last_res;

  task automatic do_access(input logic [5:0] op, input logic [4:0] ra,
                           input logic [4:0] rb, input logic [15:0] imm,
                           input logic [31:0] base, input logic [31:0] sdata,
                           input logic [31:0] rword, input int stall, input int lat);
    int          sz;
    logic [31:0] ea;
    logic [31:0] instr;
    logic [31:0] ev;
    sz    = op_size(op);
    instr = {ra, rb, imm, op};
    ea    = base + {{16{imm[15]}}, imm};
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 idle ready", 32'(req_ready), 32'h1);
    req_valid = 1'b1; req_instr = instr; req_base = base; req_store_data = sdata;
    #1;
    chk(src_a_idx == ra, "R1 src_a_idx", 32'(src_a_idx), 32'(ra));
    @(negedge clk);
    req_valid = 1'b0;
    if (sz < 0) begin
      chk(mem_valid == 1'b0, "R9 no bus request", 32'(mem_valid), 32'h0);
      @(negedge clk);
      chk(res_valid == 1'b0 && mem_valid == 1'b0, "R9 no result",
          32'(res_valid), 32'h0);
      return;
    end
    chk(req_ready == 1'b0, "R8 busy", 32'(req_ready), 32'h0);
    for (int s = 0; s < stall; s++) begin
      chk(mem_valid == 1'b1 && mem_addr == ea, "R6 stall hold", mem_addr, ea);
      @(negedge clk);
    end
    chk(mem_valid == 1'b1, "R6 valid at handshake", 32'(mem_valid), 32'h1);
    chk(mem_addr == ea, "R1 address", mem_addr, ea);
    chk(mem_be == exp_be(sz, ea[1:0]), "R2 lane enables", 32'(mem_be),
        32'(exp_be(sz, ea[1:0])));
    chk(mem_write == op_store(op), "R3 write flag", 32'(mem_write), 32'(op_store(op)));
    chk(mem_bypass == op[5], "R5 bypass flag", 32'(mem_bypass), 32'(op[5]));
    if (op_store(op))
      chk(mem_wdata == exp_wdata(sz, sdata), "R3 store lanes", mem_wdata,
          exp_wdata(sz, sdata));
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
    chk(mem_valid == 1'b0, "R6 request retired", 32'(mem_valid), 32'h0);
    if (op_store(op)) begin
      chk(res_valid == 1'b0, "R7 store gives no result", 32'(res_valid), 32'h0);
      @(negedge clk);
      chk(res_valid == 1'b0, "R7 store gives no result", 32'(res_valid), 32'h0);
      return;
    end
    for (int d = 0; d < lat; d++) begin
      chk(res_valid == 1'b0 && req_ready == 1'b0, "R7 no early result",
          32'(res_valid), 32'h0);
      @(negedge clk);
    end
    mem_rvalid = 1'b1; mem_rdata = rword;
    @(negedge clk);
    mem_rvalid = 1'b0; mem_rdata = $urandom;
    ev = exp_load(sz, op_signed(op), ea[1:0], rword);
    chk(res_valid == 1'b1, "R7 result pulse", 32'(res_valid), 32'h1);
    chk(res_rd == rb, "R7 destination index", 32'(res_rd), 32'(rb));
    chk(res_data == ev, "R4 load value", res_data, ev);
    last_res = res_data;
    @(negedge clk);
    chk(res_valid == 1'b0, "R7 single pulse", 32'(res_valid), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [5:0]  ops [16];
    logic [31:0] r_a;
    logic [31:0] r_b;
    void'($urandom(32'h5EED_1234));
    ops = '{6'h03, 6'h23, 6'h07, 6'h27, 6'h0B, 6'h2B, 6'h0F, 6'h2F,
            6'h17, 6'h37, 6'h05, 6'h25, 6'h0D, 6'h2D, 6'h15, 6'h35};
    repeat (3) @(negedge clk);
    // R10 reset values
    chk(req_ready == 1'b1, "R10 ready in reset", 32'(req_ready), 32'h1);
    chk(mem_valid == 1'b0, "R10 no request in reset", 32'(mem_valid), 32'h0);
    chk(res_valid == 1'b0, "R10 no result in reset", 32'(res_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 signed byte at every lane, R1 negative immediate
    for (int o = 0; o < 4; o++)
      do_access(6'h07, 5'd3, 5'd9, 16'hFFFC, 32'h0000_1004 + 32'(o), 32'h0,
                32'h80_80_80_80 ^ (32'h1 << (8*o)), 1, 0);
    do_access(6'h03, 5'd1, 5'd2, 16'h8000, 32'h0001_0003, 32'h0, 32'hF0E1_D2C3, 0, 1);
    // R4 halfword signed in upper half
    do_access(6'h0F, 5'd4, 5'd5, 16'h0002, 32'h0000_2000, 32'h0, 32'h8001_7FFF, 2, 2);
    do_access(6'h0B, 5'd4, 5'd5, 16'h0002, 32'h0000_2000, 32'h0, 32'h8001_7FFF, 0, 0);
    // R5 bypass pair yields identical results
    do_access(6'h0F, 5'd6, 5'd7, 16'h0000, 32'h0000_3000, 32'h0, 32'h1234_9ABC, 0, 0);
    r_a = last_res;
    do_access(6'h2F, 5'd6, 5'd7, 16'h0000, 32'h0000_3000, 32'h0, 32'h1234_9ABC, 0, 0);
    r_b = last_res;
    chk(r_a == r_b, "R5 bypass form same result", r_b, r_a);
    // R3 stores of each width
    do_access(6'h05, 5'd8, 5'd9, 16'h0003, 32'h100, 32'hDEAD_BEA5, 32'h0, 1, 0);
    do_access(6'h2D, 5'd8, 5'd9, 16'h0002, 32'h100, 32'hDEAD_BEA5, 32'h0, 0, 0);
    do_access(6'h15, 5'd8, 5'd9, 16'hFFF0, 32'h110, 32'hDEAD_BEA5, 32'h0, 3, 0);
    // R9 non-memory opcodes
    do_access(6'h04, 5'd1, 5'd1, 16'h0010, 32'h0, 32'h0, 32'h0, 0, 0);
    do_access(6'h3A, 5'd1, 5'd1, 16'h0010, 32'h0, 32'h0, 32'h0, 0, 0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [5:0]  op;
      logic [15:0] imm;
      logic [31:0] base;
      logic [31:0] ea;
      int          sz;
      if (($urandom % 10) == 0) op = 6'($urandom % 64);
      else op = ops[$urandom % 16];
      imm  = 16'($urandom);
      base = $urandom;
      sz   = op_size(op);
      ea   = base + {{16{imm[15]}}, imm};
      if (sz == 1) base = base - (ea & 32'h1);
      if (sz == 2) base = base - (ea & 32'h3);
      do_access(op, 5'($urandom), 5'($urandom), imm, base, $urandom, $urandom,
                int'($urandom % 4), int'($urandom % 3));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule